// File: doc/BRIEF.md
# Channel Fault Latch and Shutdown Controller

This block is the protection controller for one channel of a low-side power switch. It takes the control request for the channel, a global enable and a standby level. It also takes two comparator flags, one for overcurrent and one for overtemperature. From these it produces a gate-drive request and a flag that shows when a fault is held. Short fault bursts are filtered out. A fault that stays present for the qualification window is held in a latch, and the gate request is forced low while the latch is set.

The latch is released only after the control input has stayed low for a whole suppression window. A brief low glitch on the control input therefore cannot restart a channel that has tripped. All timing comes from the free-running block clock through two counters whose lengths are parameters, given in clock cycles. Standby makes the channel inactive and releases the latch.

Top module: `chan_guard`

## Requirements
- R1: `gateReq` is high exactly when `ctlIn`, `enaIn` and `stbyIn` are all high and `faultLatched` is low. An input that is not driven (held low) keeps the gate off.
- R2: `ocFlag` and `otFlag` each count as the fault condition on their own. Their OR is what gets qualified.
- R3: While `stbyIn` is high and no fault is held, a fault condition sampled high on `QUAL_CYC` consecutive clock edges sets `faultLatched` at the last of those edges. From that edge onward `gateReq` is low. A condition that lasts fewer edges never sets the latch.
- R4: When the fault condition is sampled low, the qualification count returns to zero. Separate bursts, each shorter than `QUAL_CYC`, do not add up.
- R5: While the latch is set and `ctlIn` stays high, the latch holds, whether or not the fault condition is still present.
- R6: While the latch is set, `ctlIn` sampled low on `SUPP_CYC` consecutive edges clears `faultLatched` at the last of those edges. A low period that lasts fewer edges leaves the latch set, even after `ctlIn` goes high again.
- R7: The synchronous reset `rst` clears the latch and both counters.
- R8: While `stbyIn` is low, `gateReq` is low, the latch is cleared at the next edge, and no fault is qualified.
- R9: A fault is qualified and latched whether `ctlIn` is high or low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running block clock |
| rst | input | 1 | Synchronous reset, active high |
| ctlIn | input | 1 | Synchronized channel control request, active high |
| enaIn | input | 1 | Global enable, active high |
| stbyIn | input | 1 | Active-mode level; low means standby |
| ocFlag | input | 1 | Overcurrent comparator flag, active high |
| otFlag | input | 1 | Overtemperature comparator flag, active high |
| gateReq | output | 1 | Gate-drive request to the output stage |
| faultLatched | output | 1 | A qualified fault is currently held |

## Verification
`gateReq` is a combinational function of the inputs and the latch, so a change in `ctlIn`, `enaIn` or `stbyIn` shows up in the same cycle. A latch set or cleared at an edge shows up just after that edge. Setting the latch takes exactly `QUAL_CYC` edges of continuous fault, and clearing it takes exactly `SUPP_CYC` edges of continuous low on `ctlIn`. The bench drives inputs on falling edges and counts a chosen number of rising edges. It samples on the next falling edge, and it places its hold lengths one edge either side of each window so that both the early and the on-time outcomes are checked.

// File: rtl/chan_guard_pkg.sv
package chan_guard_pkg;

  // strobes from control to the timing datapath
  typedef struct packed {
    logic qualRun;
    logic suppRun;
  } tmrCmd_t;

  // window-complete events back from the datapath
  typedef struct packed {
    logic qualDone;
    logic suppDone;
  } tmrEvt_t;

  typedef enum logic {
    ST_WATCH = 1'b0,
    ST_TRIP  = 1'b1
  } guardState_t;

endpackage

// File: rtl/chan_guard_tmr.sv
module chan_guard_tmr #(
  parameter int LIMIT = 2500
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic done
);
  localparam int CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt;

  // done fires on the edge that completes LIMIT consecutive run cycles
  assign done = run && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst || !run || done) cnt <= '0;
    else                     cnt <= cnt + 1'b1;
  end

  // R3 / R6: the window counter never passes its last value
  p_cnt_bound_r3: assert property (@(posedge clk) disable iff (rst)
    cnt <= LAST);

endmodule

// File: rtl/chan_guard_dp.sv
module chan_guard_dp
  import chan_guard_pkg::*;
#(
  parameter int QUAL_CYC = 2500,
  parameter int SUPP_CYC = 2500
) (
  input  logic    clk,
  input  logic    rst,
  input  tmrCmd_t cmd,
  output tmrEvt_t evt
);
  localparam int NTMR = 2;

  logic [NTMR-1:0] runVec;
  logic [NTMR-1:0] doneVec;

  assign runVec = {cmd.suppRun, cmd.qualRun};

  for (genvar g = 0; g < NTMR; g++) begin : g_tmr
    localparam int LIM = (g == 0) ? QUAL_CYC : SUPP_CYC;
    chan_guard_tmr #(.LIMIT(LIM)) i_tmr (
      .clk  (clk),
      .rst  (rst),
      .run  (runVec[g]),
      .done (doneVec[g])
    );
  end

  assign evt.qualDone = doneVec[0];
  assign evt.suppDone = doneVec[1];

endmodule

// File: rtl/chan_guard_ctrl.sv
module chan_guard_ctrl
  import chan_guard_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    ctlIn,
  input  logic    stbyIn,
  input  logic    faultCond,
  input  tmrEvt_t evt,
  output tmrCmd_t cmd,
  output logic    latched
);
  guardState_t state;

  always_ff @(posedge clk) begin
    if (rst || !stbyIn) begin
      state <= ST_WATCH;
    end else begin
      case (state)
        ST_WATCH: if (evt.qualDone) state <= ST_TRIP;
        ST_TRIP:  if (evt.suppDone) state <= ST_WATCH;
        default:  state <= ST_WATCH;
      endcase
    end
  end

  assign latched     = (state == ST_TRIP);
  assign cmd.qualRun = stbyIn && faultCond && (state == ST_WATCH);
  assign cmd.suppRun = stbyIn && !ctlIn && (state == ST_TRIP);

  // R3: a latch set is always preceded by a present fault
  p_set_on_fault_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(latched) |-> $past(faultCond));

  // R6: a release outside reset only follows a low control input or standby
  p_clear_on_low_r6: assert property (@(posedge clk) disable iff (rst)
    ($fell(latched) && !$past(rst)) |-> (!$past(ctlIn) || !$past(stbyIn)));

  // R5: control held high keeps a held fault held
  p_hold_high_r5: assert property (@(posedge clk) disable iff (rst)
    (latched && ctlIn && stbyIn) |=> latched);

  // R8: standby releases the latch at the next edge
  p_standby_clr_r8: assert property (@(posedge clk) disable iff (rst)
    !stbyIn |=> !latched);

endmodule

// File: rtl/chan_guard.sv
module chan_guard
  import chan_guard_pkg::*;
#(
  parameter int QUAL_CYC = 2500,
  parameter int SUPP_CYC = 2500
) (
  input  logic clk,
  input  logic rst,
  input  logic ctlIn,
  input  logic enaIn,
  input  logic stbyIn,
  input  logic ocFlag,
  input  logic otFlag,
  output logic gateReq,
  output logic faultLatched
);
  tmrCmd_t cmd;
  tmrEvt_t evt;
  logic    faultCond;
  logic    latched;

  assign faultCond = ocFlag | otFlag;

  chan_guard_ctrl i_ctrl (
    .clk       (clk),
    .rst       (rst),
    .ctlIn     (ctlIn),
    .stbyIn    (stbyIn),
    .faultCond (faultCond),
    .evt       (evt),
    .cmd       (cmd),
    .latched   (latched)
  );

  chan_guard_dp #(.QUAL_CYC(QUAL_CYC), .SUPP_CYC(SUPP_CYC)) i_dp (
    .clk (clk),
    .rst (rst),
    .cmd (cmd),
    .evt (evt)
  );

  assign faultLatched = latched;
  assign gateReq      = ctlIn & enaIn & stbyIn & ~latched;

endmodule

// File: tb/test_chan_guard.sv
`timescale 1ns/1ps
module test_chan_guard;
  localparam int QC = 8;
  localparam int SC = 6;

  typedef struct packed {
    logic       ctl;
    logic       ena;
    logic       stby;
    logic       oc;
    logic       ot;
    logic [7:0] hold;
    logic       expGate;
    logic       expLatch;
    logic [3:0] req;
  } vec_t;

  localparam int NV = 21;
  localparam vec_t VECS [NV] = '{
    '{1'b1,1'b1,1'b1,1'b0,1'b0, 8'd2, 1'b1,1'b0, 4'd1}, // R1 all high
    '{1'b1,1'b0,1'b1,1'b0,1'b0, 8'd1, 1'b0,1'b0, 4'd1}, // R1 enable low
    '{1'b1,1'b1,1'b0,1'b0,1'b0, 8'd1, 1'b0,1'b0, 4'd8}, // R8 standby gate off
    '{1'b0,1'b1,1'b1,1'b0,1'b0, 8'd1, 1'b0,1'b0, 4'd1}, // R1 control low
    '{1'b1,1'b1,1'b1,1'b1,1'b0, 8'd7, 1'b1,1'b0, 4'd3}, // R3 one edge short
    '{1'b1,1'b1,1'b1,1'b0,1'b0, 8'd1, 1'b1,1'b0, 4'd4}, // R4 dropout
    '{1'b1,1'b1,1'b1,1'b0,1'b1, 8'd7, 1'b1,1'b0, 4'd4}, // R4 count restarted
    '{1'b1,1'b1,1'b1,1'b0,1'b1, 8'd1, 1'b0,1'b1, 4'd2}, // R2 temp flag trips
    '{1'b1,1'b1,1'b1,1'b0,1'b0, 8'd3, 1'b0,1'b1, 4'd5}, // R5 held with IN high
    '{1'b0,1'b1,1'b1,1'b0,1'b0, 8'd5, 1'b0,1'b1, 4'd6}, // R6 low one edge short
    '{1'b1,1'b1,1'b1,1'b0,1'b0, 8'd2, 1'b0,1'b1, 4'd6}, // R6 no restart
    '{1'b0,1'b1,1'b1,1'b0,1'b0, 8'd6, 1'b0,1'b0, 4'd6}, // R6 full low clears
    '{1'b1,1'b1,1'b1,1'b0,1'b0, 8'd1, 1'b1,1'b0, 4'd6}, // R6 restart
    '{1'b1,1'b1,1'b1,1'b1,1'b0, 8'd8, 1'b0,1'b1, 4'd3}, // R3 current flag trips
    '{1'b1,1'b1,1'b0,1'b0,1'b0, 8'd1, 1'b0,1'b0, 4'd8}, // R8 standby clears
    '{1'b1,1'b1,1'b1,1'b0,1'b0, 8'd1, 1'b1,1'b0, 4'd8}, // R8 back active
    '{1'b1,1'b1,1'b0,1'b1,1'b0, 8'd10,1'b0,1'b0, 4'd8}, // R8 no qual in standby
    '{1'b1,1'b1,1'b1,1'b0,1'b0, 8'd1, 1'b1,1'b0, 4'd8}, // R8 nothing carried
    '{1'b0,1'b1,1'b1,1'b1,1'b0, 8'd8, 1'b0,1'b1, 4'd9}, // R9 trip with IN low
    '{1'b0,1'b1,1'b1,1'b0,1'b0, 8'd6, 1'b0,1'b0, 4'd6}, // R6 clear after trip
    '{1'b1,1'b1,1'b1,1'b0,1'b0, 8'd1, 1'b1,1'b0, 4'd1}  // R1 normal again
  };

  logic clk = 1'b0;
  logic rst, ctlIn, enaIn, stbyIn, ocFlag, otFlag;
  logic gateReq, faultLatched;
  int   nChecks = 0;
  int   nFails  = 0;
  bit   doneFlag = 1'b0;

  always #2 clk = ~clk;

  chan_guard #(.QUAL_CYC(QC), .SUPP_CYC(SC)) i_chan_guard (
    .clk          (clk),
    .rst          (rst),
    .ctlIn        (ctlIn),
    .enaIn        (enaIn),
    .stbyIn       (stbyIn),
    .ocFlag       (ocFlag),
    .otFlag       (otFlag),
    .gateReq      (gateReq),
    .faultLatched (faultLatched)
  );

  task automatic chk(input string tag, input logic act, input logic exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic finishRun();
    if (!doneFlag) begin
      doneFlag = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog expired actual=running expected=done");
    finishRun();
  end

  initial begin
    rst = 1'b1; ctlIn = 1'b0; enaIn = 1'b0; stbyIn = 1'b0;
    ocFlag = 1'b0; otFlag = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    chk("R7 reset gate", gateReq, 1'b0);
    chk("R7 reset latch", faultLatched, 1'b0);

    for (int i = 0; i < NV; i++) begin
      ctlIn  = VECS[i].ctl;
      enaIn  = VECS[i].ena;
      stbyIn = VECS[i].stby;
      ocFlag = VECS[i].oc;
      otFlag = VECS[i].ot;
      repeat (int'(VECS[i].hold)) @(posedge clk);
      @(negedge clk);
      chk($sformatf("R%0d vec%0d gate", VECS[i].req, i), gateReq, VECS[i].expGate);
      chk($sformatf("R%0d vec%0d latch", VECS[i].req, i), faultLatched, VECS[i].expLatch);
    end

    // R7: reset releases a held fault
    ctlIn = 1'b1; ocFlag = 1'b1;
    repeat (QC) @(posedge clk);
    @(negedge clk);
    chk("R3 trip before reset", faultLatched, 1'b1);
    rst = 1'b1; ocFlag = 1'b0;
    @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    chk("R7 reset clears latch", faultLatched, 1'b0);
    chk("R7 gate after reset", gateReq, 1'b1);

    // R4 / R7: counter was cleared by reset, a short burst stays harmless
    ocFlag = 1'b1;
    repeat (QC - 1) @(posedge clk);
    @(negedge clk);
    chk("R4 short burst after reset", faultLatched, 1'b0);
    ocFlag = 1'b0;
    @(negedge clk);

    finishRun();
  end
endmodule